// File: doc/BRIEF.md
# UART Baud Divisor Generator

This block divides the system clock by a programmable 16-bit value and emits a one-cycle `tick_o` enable for the serial shift logic of a UART. Software sets the divisor through a byte-wide register port. The two divisor bytes share their addresses with the data buffer location and the interrupt-enable location. Bit 7 of a line-control register picks which of the two each shared address reaches.

When the select bit is clear, an access to a shared address raises a pass-through select toward the data or interrupt-enable logic, and the divisor does not change. When the select bit is set, the same addresses read and write the divisor bytes. A write to either byte reloads the counter with the full new value, so the baud phase restarts at once.

Address map: 0 is the data location or the low divisor byte. 1 is the interrupt-enable location or the high divisor byte. 3 is line control. All other addresses are unmapped.

Top module: `uart_baud_div`

## Requirements
- R1: After reset the divisor is 0x0002, line control is 0x00, and `tick_o` is low in the first cycle and high in the second.
- R2: While line-control bit 7 is 0, writes to addresses 0 and 1 leave the divisor unchanged.
- R3: A write to either divisor byte (address 0 or 1 with bit 7 set) loads the full 16-bit value into the counter. For a new divisor D >= 2, `tick_o` next goes high in the D-th cycle after the write, counting the cycle after the write edge as the first.
- R4: With a steady divisor D >= 2, `tick_o` is high for exactly one cycle in every D cycles.
- R5: A divisor of 0x0001 or 0x0000 makes `tick_o` high on every cycle.
- R6: With bit 7 set, a read of address 0 returns the low divisor byte and a read of address 1 returns the high byte, so the divisor reads back as {high, low}.
- R7: With bit 7 clear, any read or write of address 0 raises `data_sel_o` and any access of address 1 raises `ier_sel_o`, in the same cycle. With bit 7 set, neither select is raised.
- R8: Line control at address 3 is readable and writable whatever the value of its bit 7.
- R9: `rdata_o` is 0 when `rd_i` is low, for unmapped addresses, and for pass-through reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| tick_o | output | 1 | One-cycle baud enable |
| data_sel_o | output | 1 | Pass-through select to the data buffer location |
| ier_sel_o | output | 1 | Pass-through select to the interrupt-enable location |

## Verification
The following rules are checked by assertions on every cycle:
- The two pass-through selects are mutually exclusive and appear only with the select bit clear.
- The divisor holds while the select bit is clear.
- A bypass divisor keeps the tick high.
- A divisor of two or more never gives two ticks in a row.
- A reload never ticks in the following cycle.

Only the bench's scenarios can show the exact tick period, the restart point after a write in the middle of a count, and the read-back values. For these, a reference model runs alongside directed writes and a long random sequence of accesses.

// File: rtl/ubd_pkg.sv
package ubd_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] A_IER  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LCR  = 3'd3;
  localparam int unsigned SEL_BIT = 7;
endpackage

// File: rtl/ubd_decode.sv
module ubd_decode
  import ubd_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              dlab_i,
  output logic [LANES-1:0]  lane_wr_o,
  output logic [LANES-1:0]  lane_rd_o,
  output logic              lcr_wr_o,
  output logic              lcr_rd_o,
  output logic              data_sel_o,
  output logic              ier_sel_o
);
  logic acc;
  assign acc = wr_i | rd_i;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lane_wr_o[i] = wr_i & dlab_i & (addr_i == ADDR_W'(int'(A_DATA) + i));
      lane_rd_o[i] = rd_i & dlab_i & (addr_i == ADDR_W'(int'(A_DATA) + i));
    end
  end

  assign lcr_wr_o   = wr_i & (addr_i == A_LCR);
  assign lcr_rd_o   = rd_i & (addr_i == A_LCR);
  assign data_sel_o = acc & ~dlab_i & (addr_i == A_DATA);
  assign ier_sel_o  = acc & ~dlab_i & (addr_i == A_IER);
endmodule

// File: rtl/ubd_regs.sv
module ubd_regs
  import ubd_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned LANES   = 2,
  parameter int unsigned DIV_W   = DATA_W * LANES,
  parameter logic [DIV_W-1:0] RST_DIV = DIV_W'(2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  lane_wr_i,
  input  logic [LANES-1:0]  lane_rd_i,
  input  logic              lcr_wr_i,
  input  logic              lcr_rd_i,
  output logic              dlab_o,
  output logic [DIV_W-1:0]  div_q_o,
  output logic [DIV_W-1:0]  div_d_o,
  output logic              ld_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] lcr_q;
  logic [DIV_W-1:0]  div_q;
  logic [DIV_W-1:0]  div_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lcr_q <= '0;
    else if (lcr_wr_i) lcr_q <= wdata_i;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign div_d[g*DATA_W +: DATA_W] = lane_wr_i[g] ? wdata_i : div_q[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= RST_DIV;
    else         div_q <= div_d;
  end

  always_comb begin
    rdata_o = '0;
    if (lcr_rd_i) rdata_o = lcr_q;
    for (int i = 0; i < LANES; i++)
      if (lane_rd_i[i]) rdata_o = div_q[i*DATA_W +: DATA_W];
  end

  assign dlab_o  = lcr_q[SEL_BIT];
  assign div_q_o = div_q;
  assign div_d_o = div_d;
  assign ld_o    = |lane_wr_i;
endmodule

// File: rtl/ubd_counter.sv
module ubd_counter #(
  parameter int unsigned DIV_W   = 16,
  parameter logic [DIV_W-1:0] RST_DIV = DIV_W'(2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [DIV_W-1:0] div_d_i,
  input  logic [DIV_W-1:0] div_q_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  // 0 and 1 both bypass
  function automatic logic [DIV_W-1:0] eff(input logic [DIV_W-1:0] d);
    return (d < DIV_W'(2)) ? ONE : d;
  endfunction

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= eff(RST_DIV);
    else if (ld_i)          cnt_q <= eff(div_d_i);
    else if (cnt_q <= ONE)  cnt_q <= eff(div_q_i);
    else                    cnt_q <= cnt_q - ONE;
  end

  assign tick_o = (cnt_q == ONE);
endmodule

// File: rtl/uart_baud_div.sv
module uart_baud_div
  import ubd_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned LANES   = 2,
  parameter int unsigned RST_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tick_o,
  output logic              data_sel_o,
  output logic              ier_sel_o
);
  localparam int unsigned DIV_W = DATA_W * LANES;
  localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(RST_DIV);

  logic [LANES-1:0] lane_wr, lane_rd;
  logic             lcr_wr, lcr_rd, dlab, ld;
  logic [DIV_W-1:0] div_q, div_d;

  ubd_decode #(.LANES(LANES)) u_dec (
    .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i), .dlab_i(dlab),
    .lane_wr_o(lane_wr), .lane_rd_o(lane_rd),
    .lcr_wr_o(lcr_wr), .lcr_rd_o(lcr_rd),
    .data_sel_o(data_sel_o), .ier_sel_o(ier_sel_o)
  );

  ubd_regs #(.DATA_W(DATA_W), .LANES(LANES), .DIV_W(DIV_W), .RST_DIV(RST_VAL)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wdata_i(wdata_i),
    .lane_wr_i(lane_wr), .lane_rd_i(lane_rd),
    .lcr_wr_i(lcr_wr), .lcr_rd_i(lcr_rd),
    .dlab_o(dlab), .div_q_o(div_q), .div_d_o(div_d), .ld_o(ld),
    .rdata_o(rdata_o)
  );

  ubd_counter #(.DIV_W(DIV_W), .RST_DIV(RST_VAL)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld),
    .div_d_i(div_d), .div_q_i(div_q), .tick_o(tick_o)
  );
endmodule

// File: rtl/uart_baud_div_chk.sv
module uart_baud_div_chk #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_o,
  input logic             data_sel_o,
  input logic             ier_sel_o,
  input logic             dlab,
  input logic             ld,
  input logic [DIV_W-1:0] div_q
);
  // R7
  sel_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({data_sel_o, ier_sel_o}));

  // R7
  sel_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_sel_o || ier_sel_o) |-> !dlab);

  // R2
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dlab |=> $stable(div_q));

  // R5
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q < DIV_W'(2)) |-> tick_o);

  // R4
  single_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !ld && div_q >= DIV_W'(2)) |=> !tick_o);

  // R3
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> (!tick_o || div_q < DIV_W'(2)));
endmodule

bind uart_baud_div uart_baud_div_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick_o),
  .data_sel_o(data_sel_o), .ier_sel_o(ier_sel_o),
  .dlab(dlab), .ld(ld), .div_q(div_q)
);

// File: tb/sim_uart_baud_div.sv
`timescale 1ns/1ps
module sim_uart_baud_div;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tick, data_sel, ier_sel;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "";

  logic [7:0]  m_lcr;
  logic [15:0] m_div, m_cnt;

  always #2 clk = ~clk;

  uart_baud_div u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .tick_o(tick),
    .data_sel_o(data_sel), .ier_sel_o(ier_sel)
  );

  function automatic logic [15:0] eff(input logic [15:0] d);
    return (d < 16'd2) ? 16'd1 : d;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] a, input logic r);
    if (!r) return 8'h00;
    if (a == 3'd3) return m_lcr;
    if (m_lcr[7] && a == 3'd0) return m_div[7:0];
    if (m_lcr[7] && a == 3'd1) return m_div[15:8];
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [2:0] a, input logic w, input logic r, input logic [7:0] d);
    string tg;
    logic ld;
    addr = a; wr = w; rd = r; wdata = d;
    #1;
    if (cur_req != "") tg = cur_req;
    else if (a == 3'd3) tg = "R8";
    else if (m_lcr[7] && a < 3'd2) tg = "R6";
    else tg = "R9";
    chk(tg, rdata, exp_rd(a, r));
    // R7 selects
    chk("R7", {data_sel, ier_sel},
        {(w | r) & ~m_lcr[7] & (a == 3'd0), (w | r) & ~m_lcr[7] & (a == 3'd1)});
    chk(cur_req != "" ? cur_req : "R4", tick, m_cnt == 16'd1);
    @(posedge clk);
    ld = 1'b0;
    if (w && m_lcr[7] && a == 3'd0) begin m_div[7:0] = d; ld = 1'b1; end
    if (w && m_lcr[7] && a == 3'd1) begin m_div[15:8] = d; ld = 1'b1; end
    if (w && a == 3'd3) m_lcr = d;
    if (ld) m_cnt = eff(m_div);
    else if (m_cnt <= 16'd1) m_cnt = eff(m_div);
    else m_cnt = m_cnt - 16'd1;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(3'd2, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_lcr = 8'h00; m_div = 16'h0002; m_cnt = 16'h0002;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state and first tick
    cur_req = "R1";
    cyc(3'd3, 1'b0, 1'b1, 8'h00);
    cyc(3'd3, 1'b0, 1'b0, 8'h00);
    cyc(3'd3, 1'b1, 1'b0, 8'h80);
    cyc(3'd0, 1'b0, 1'b1, 8'h00);
    cyc(3'd1, 1'b0, 1'b1, 8'h00);

    // R6 read back
    cur_req = "R6";
    cyc(3'd0, 1'b1, 1'b0, 8'h34);
    cyc(3'd1, 1'b1, 1'b0, 8'h12);
    cyc(3'd0, 1'b0, 1'b1, 8'h00);
    cyc(3'd1, 1'b0, 1'b1, 8'h00);

    // R3 restart on either byte write
    cur_req = "R3";
    cyc(3'd0, 1'b1, 1'b0, 8'h05);
    cyc(3'd1, 1'b1, 1'b0, 8'h00);
    idle(12);
    cyc(3'd0, 1'b1, 1'b0, 8'h07);
    idle(3);
    cyc(3'd1, 1'b1, 1'b0, 8'h00);
    idle(16);

    // R5 bypass with 1 and 0
    cur_req = "R5";
    cyc(3'd0, 1'b1, 1'b0, 8'h01);
    idle(5);
    cyc(3'd0, 1'b1, 1'b0, 8'h00);
    idle(5);

    // R4 steady period
    cur_req = "R4";
    cyc(3'd0, 1'b1, 1'b0, 8'h03);
    idle(12);

    // R2 writes blocked while select bit clear; R7 selects raised
    cur_req = "R2";
    cyc(3'd3, 1'b1, 1'b0, 8'h03);
    cyc(3'd0, 1'b1, 1'b0, 8'h55);
    cyc(3'd1, 1'b1, 1'b0, 8'h66);
    cyc(3'd0, 1'b0, 1'b1, 8'h00);
    cyc(3'd1, 1'b0, 1'b1, 8'h00);
    idle(6);
    cyc(3'd3, 1'b1, 1'b0, 8'h83);
    cyc(3'd0, 1'b0, 1'b1, 8'h00);
    cyc(3'd1, 1'b0, 1'b1, 8'h00);

    // R8 line control access in both states
    cur_req = "R8";
    cyc(3'd3, 1'b1, 1'b0, 8'h5a);
    cyc(3'd3, 1'b0, 1'b1, 8'h00);
    cyc(3'd3, 1'b1, 1'b0, 8'hc1);
    cyc(3'd3, 1'b0, 1'b1, 8'h00);

    // R9 zero read data cases
    cur_req = "R9";
    cyc(3'd3, 1'b0, 1'b0, 8'h00);
    for (int a = 2; a < 8; a++) if (a != 3) cyc(3'(a), 1'b0, 1'b1, 8'h00);
    cyc(3'd3, 1'b1, 1'b0, 8'h00);
    cyc(3'd0, 1'b0, 1'b1, 8'h00);
    cyc(3'd1, 1'b0, 1'b1, 8'h00);

    // random mix
    cur_req = "";
    for (int n = 0; n < 4000; n++) begin
      int sel;
      logic [2:0] a;
      logic [7:0] d;
      sel = int'($urandom_range(0, 9));
      if (sel < 6) idle(1);
      else begin
        a = 3'($urandom_range(0, 7));
        if (a == 3'd1) d = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h00;
        else if (a == 3'd0) d = 8'($urandom_range(0, 12));
        else d = 8'($urandom);
        if ($urandom_range(0, 1) == 1) cyc(a, 1'b1, 1'b0, d);
        else cyc(a, 1'b0, 1'b1, d);
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule